// File: doc/BRIEF.md
# CSMA-CA Random Backoff Controller

This block runs unslotted carrier-sense multiple access with collision avoidance for one transmit request at a time. After a start request it pulses a request to a clear-channel detector and then waits for one of two result pulses. An idle result ends the sequence at once with a clear status, and the transmitter may go ahead. A busy result makes the block draw a pseudo-random number of backoff periods. It waits that many periods, counted on a one-microsecond tick, and then asks for another assessment. The block stops with a channel-busy status once the retry budget is used up.

The random source is a 32-bit xorshift generator. The number of backoff periods is the generated word masked to its low BE bits. The backoff exponent BE starts at its minimum for every request, grows by one on each busy result, and stops at its maximum. The generator state carries over from one request to the next.

The controller has five named states. IDLE waits for a request. ISSUE drives the assessment pulse. WAIT_CCA waits for a result. BACKOFF counts ticks. DONE drives the done pulse.

The transitions are:
- IDLE→ISSUE on a start request.
- ISSUE→WAIT_CCA always.
- WAIT_CCA→DONE on an idle result.
- WAIT_CCA→BACKOFF on a busy result with a non-zero draw.
- WAIT_CCA→ISSUE on a busy result with a zero draw.
- WAIT_CCA→DONE on a busy result once the retries are used up.
- BACKOFF→ISSUE when the wait expires.
- DONE→IDLE always.

Top module: `csma_backoff_ctrl`

## Requirements
- R1: While reset is held and after it is released, `cca_start` and `done` are 0 and `status_busy` is 0 (clear).
- R2: A `start_req` sampled in IDLE drives `cca_start` high in the following cycle, for exactly one cycle.
- R3: An idle result (`cca_idle`) sampled while waiting for a result pulses `done` for one cycle in the next cycle, with `status_busy` = 0. `status_busy` keeps its value until the next `done`.
- R4: On a busy result sampled while fewer than MAX_RETRY (4) retries have been taken, the retry count and the exponent each go up by one. The exponent starts at MIN_BE (3) for each request and is held at MAX_BE (5). The wait is (draw & (2^BE − 1)) × PERIOD_US ticks, where BE is the updated exponent. PERIOD_US defaults to 320 (20 symbols).
- R5: The draw is the next state of a 32-bit xorshift generator: x ^= x<<13, then x ^= x>>17, then x ^= x<<5. The generator is seeded with 0xDEADBEEF at reset, steps once per retry draw, and is not reseeded between requests.
- R6: A draw of zero periods skips the wait: `cca_start` rises in the cycle right after the busy result is sampled.
- R7: The wait advances only on cycles with `tick_us` high. With N = periods × PERIOD_US > 0 and `tick_us` held high, `cca_start` rises N+2 cycles after the busy result is sampled. Every cycle in BACKOFF with `tick_us` low adds one cycle.
- R8: A busy result sampled after MAX_RETRY retries pulses `done` in the next cycle with `status_busy` = 1, and no further `cca_start` follows.
- R9: `start_req` outside IDLE, and `cca_idle`/`cca_busy` outside the result-wait state, have no effect.
- R10: When `cca_idle` and `cca_busy` are sampled together while waiting for a result, the idle result takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request to begin a sequence |
| cca_idle | input | 1 | Assessment result pulse: medium idle |
| cca_busy | input | 1 | Assessment result pulse: medium busy |
| tick_us | input | 1 | One-microsecond time base pulse |
| cca_start | output | 1 | Pulse asking the detector for an assessment |
| done | output | 1 | Pulse marking the end of the sequence |
| status_busy | output | 1 | Result of the last sequence: 1 channel busy, 0 clear |

## Verification
Every wrong internal value shows up as a shift in the timing of `cca_start`. A wrong generator state, exponent or mask changes the length of the next backoff, and the bench measures that length to the cycle against its own xorshift model. A retry count that is off shows up as `done` with the wrong status, one busy result too early or too late. A state that fails to return to IDLE shows up on the next request as a missing `cca_start` one cycle after `start_req`.

// File: rtl/csma_pkg.sv
package csma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_CCA,
        ST_BACKOFF,
        ST_DONE
    } csma_state_t;

    function automatic logic [31:0] xorshift32(input logic [31:0] x);
        logic [31:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

endpackage

// File: rtl/csma_prng.sv
module csma_prng #(
    parameter logic [31:0] SEED  = 32'hDEAD_BEEF,
    parameter int          OUT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] draw_bits
);
    import csma_pkg::*;

    logic [31:0] state_q;
    logic [31:0] state_nxt;

    assign state_nxt = xorshift32(state_q);
    assign draw_bits = state_nxt[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n)    state_q <= SEED;
        else if (step) state_q <= state_nxt;
    end

    // xorshift never reaches the all-zero state from a non-zero seed
    p_state_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 32'd0);

    p_hold_without_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

endmodule

// File: rtl/csma_draw_scale.sv
module csma_draw_scale #(
    parameter int MAX_BE    = 5,
    parameter int PERIOD_US = 320,
    parameter int BE_W      = 3,
    parameter int WAIT_W    = 14
) (
    input  logic [MAX_BE-1:0] rand_bits,
    input  logic [BE_W-1:0]   be,
    output logic [WAIT_W-1:0] wait_ticks,
    output logic              zero_draw
);
    localparam logic [WAIT_W-1:0] PER = WAIT_W'(PERIOD_US);

    logic [MAX_BE-1:0] mask;
    logic [MAX_BE-1:0] periods;

    for (genvar g = 0; g < MAX_BE; g++) begin : g_mask
        assign mask[g] = (be > BE_W'(g));
    end

    assign periods    = rand_bits & mask;
    assign zero_draw  = (periods == '0);
    assign wait_ticks = WAIT_W'(periods) * PER;

endmodule

// File: rtl/csma_wait_timer.sv
module csma_wait_timer #(
    parameter int WAIT_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    input  logic              tick,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (load)                      cnt_q <= load_val;
        else if (run && tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && cnt_q != '0 |=> cnt_q <= $past(cnt_q));

    p_no_tick_no_progress_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !tick |=> $stable(cnt_q));

endmodule

// File: rtl/csma_backoff_ctrl.sv
module csma_backoff_ctrl #(
    parameter int          MIN_BE    = 3,
    parameter int          MAX_BE    = 5,
    parameter int          MAX_RETRY = 4,
    parameter int          PERIOD_US = 320,
    parameter logic [31:0] SEED      = 32'hDEAD_BEEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic cca_idle,
    input  logic cca_busy,
    input  logic tick_us,
    output logic cca_start,
    output logic done,
    output logic status_busy
);
    import csma_pkg::*;

    localparam int BE_W   = $clog2(MAX_BE + 1);
    localparam int ATT_W  = $clog2(MAX_RETRY + 1);
    localparam int WAIT_W = $clog2(((1 << MAX_BE) - 1) * PERIOD_US + 1);

    csma_state_t       state_q, state_d;
    logic [BE_W-1:0]   be_q, be_next;
    logic [ATT_W-1:0]  att_q;
    logic              status_q;
    logic              busy_retry, busy_giveup, idle_hit;
    logic [MAX_BE-1:0] draw_bits;
    logic [WAIT_W-1:0] wait_ticks;
    logic              zero_draw;
    logic              expired;

    assign idle_hit    = (state_q == ST_WAIT_CCA) && cca_idle;
    assign busy_retry  = (state_q == ST_WAIT_CCA) && !cca_idle && cca_busy
                         && (att_q < ATT_W'(MAX_RETRY));
    assign busy_giveup = (state_q == ST_WAIT_CCA) && !cca_idle && cca_busy
                         && (att_q >= ATT_W'(MAX_RETRY));
    assign be_next     = (be_q < BE_W'(MAX_BE)) ? be_q + 1'b1 : be_q;

    csma_prng #(.SEED(SEED), .OUT_W(MAX_BE)) u_prng (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (busy_retry),
        .draw_bits (draw_bits)
    );

    csma_draw_scale #(
        .MAX_BE(MAX_BE), .PERIOD_US(PERIOD_US), .BE_W(BE_W), .WAIT_W(WAIT_W)
    ) u_scale (
        .rand_bits  (draw_bits),
        .be         (be_next),
        .wait_ticks (wait_ticks),
        .zero_draw  (zero_draw)
    );

    csma_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (busy_retry),
        .load_val (wait_ticks),
        .run      (state_q == ST_BACKOFF),
        .tick     (tick_us),
        .expired  (expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_req) state_d = ST_ISSUE;
            ST_ISSUE:    state_d = ST_WAIT_CCA;
            ST_WAIT_CCA: begin
                if (idle_hit || busy_giveup) state_d = ST_DONE;
                else if (busy_retry)         state_d = zero_draw ? ST_ISSUE : ST_BACKOFF;
            end
            ST_BACKOFF:  if (expired) state_d = ST_ISSUE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            be_q     <= BE_W'(MIN_BE);
            att_q    <= '0;
            status_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_req) begin
                be_q  <= BE_W'(MIN_BE);
                att_q <= '0;
            end else if (busy_retry) begin
                be_q  <= be_next;
                att_q <= att_q + 1'b1;
            end
            if (idle_hit)         status_q <= 1'b0;
            else if (busy_giveup) status_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cca_start   = (state_q == ST_ISSUE);
        done        = (state_q == ST_DONE);
        status_busy = status_q;
    end

    p_cca_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cca_start |=> !cca_start);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_be_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        be_q >= BE_W'(MIN_BE) && be_q <= BE_W'(MAX_BE));

    p_zero_draw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_retry && zero_draw |=> cca_start);

    p_att_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        att_q <= ATT_W'(MAX_RETRY));

    p_fail_at_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && status_busy |-> att_q == ATT_W'(MAX_RETRY));

    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BACKOFF && start_req |=> att_q == $past(att_q) && be_q == $past(be_q));

    p_idle_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT_CCA && cca_idle && cca_busy |=> done && !status_busy);

endmodule

// File: tb/sim_csma_backoff_ctrl.sv
module sim_csma_backoff_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 8;
    localparam int MAXR       = 4;

    logic clk = 0, rst_n = 0;
    logic start_req = 0, cca_idle = 0, cca_busy = 0, tick_us = 1;
    logic cca_start, done, status_busy;

    int n_chk = 0, n_bad = 0, cycles = 0, zeros = 0;
    logic [31:0] m_rng = 32'hDEAD_BEEF;
    int m_att, m_be;

    // each entry: {number of busy results, expected channel-busy outcome}
    localparam logic [4:0] VEC [6] = '{5'b0000_0, 5'b0001_0, 5'b0011_0,
                                       5'b0101_1, 5'b0010_0, 5'b0100_0};

    always #(CLK_PERIOD/2) clk = ~clk;

    csma_backoff_ctrl #(.PERIOD_US(P)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cca_idle(cca_idle),
        .cca_busy(cca_busy), .tick_us(tick_us), .cca_start(cca_start),
        .done(done), .status_busy(status_busy));

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] t;
        t = x ^ (x << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            summary();
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    // one request; returns 1 if it ended with channel-busy status
    task automatic do_req(input int nbusy, input bit disturb, input int hold,
                          input bit both, output bit failed);
        int n, cyc, expc;
        failed = 0;
        start_req = 1; step(); start_req = 0;
        check(cca_start == 1, "R2 cca_start after start", cca_start, 1);
        step();
        check(cca_start == 0, "R2 cca_start one cycle", cca_start, 0);
        m_att = 0; m_be = 3;
        for (int k = 0; k < nbusy; k++) begin
            cca_busy = 1; step(); cca_busy = 0;
            if (m_att >= MAXR) begin
                check(done == 1 && status_busy == 1, "R8 give up status",
                      {done, status_busy}, 3);
                step();
                check(done == 0, "R8 done pulse", done, 0);
                for (int j = 0; j < 6; j++) begin
                    check(cca_start == 0, "R8 no further cca_start", cca_start, 0);
                    step();
                end
                failed = 1;
                return;
            end
            m_att++;
            if (m_be < 5) m_be++;
            m_rng = xs(m_rng);
            n = int'(m_rng & ((32'd1 << m_be) - 1)) * P;
            if (n == 0) zeros++;
            expc = (n == 0) ? 1 : n + 2 + hold;
            cyc = 1;
            if (hold > 0 && n > 0) tick_us = 0;
            while (!cca_start && cyc < 20000) begin
                if (disturb && cyc == 2) begin start_req = 1; cca_idle = 1; end
                step();
                start_req = 0; cca_idle = 0;
                cyc++;
                if (cyc == hold + 1) tick_us = 1;
            end
            tick_us = 1;
            if (n == 0) check(cyc == expc, "R6 zero draw retry", cyc, expc);
            else if (hold > 0) check(cyc == expc, "R7 tick gating", cyc, expc);
            else if (disturb) check(cyc == expc, "R9 ignored pulses in backoff", cyc, expc);
            else check(cyc == expc, "R4 R5 R7 backoff length", cyc, expc);
            step();
            check(cca_start == 0, "R2 retry pulse width", cca_start, 0);
        end
        cca_idle = 1; cca_busy = both; step(); cca_idle = 0; cca_busy = 0;
        check(done == 1 && status_busy == 0, both ? "R10 idle wins" : "R3 clear status",
              {done, status_busy}, 2);
        step();
        check(done == 0 && status_busy == 0, "R3 done pulse and held status",
              {done, status_busy}, 0);
    endtask

    initial begin
        bit f;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(cca_start == 0 && done == 0 && status_busy == 0, "R1 during reset",
              {cca_start, done, status_busy}, 0);
        rst_n = 1; step();
        check(cca_start == 0 && done == 0 && status_busy == 0, "R1 after reset",
              {cca_start, done, status_busy}, 0);

        // R9 result pulses in IDLE do nothing
        cca_idle = 1; cca_busy = 1; step(); cca_idle = 0; cca_busy = 0;
        check(done == 0 && cca_start == 0, "R9 results ignored in idle",
              {done, cca_start}, 0);

        // table of request scripts
        for (int i = 0; i < 6; i++) begin
            do_req(int'(VEC[i][4:1]), 0, 0, 0, f);
            check(f == VEC[i][0], "R8 R4 outcome vs table", f, VEC[i][0]);
            if (f) check(status_busy == 1, "R3 busy status held", status_busy, 1);
            step();
        end

        // R9 start and idle pulses during backoff are ignored
        do_req(3, 1, 0, 0, f);
        step();
        // R7 tick gating
        do_req(2, 0, 15, 0, f);
        step();
        // R10 simultaneous results
        do_req(0, 0, 0, 1, f);
        step();
        do_req(1, 0, 0, 1, f);
        step();

        // R6 sweep for zero draws
        for (int i = 0; i < 128; i++) begin
            do_req(1, 0, 0, 0, f);
            step();
        end
        check(zeros > 0, "R6 zero draw exercised", zeros, 1);
        summary();
    end
endmodule